// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer with Waveform Output

This block is an 8-bit up/down counter with one compare channel, read and written through a small four-register port. The counter advances on a count tick. The tick comes from a free-running 10-bit divider of the system clock, or from the chosen edge of an external input that is first synchronised. When no source is selected, the counter stops and keeps its value. There are four counting modes: plain wrap-around counting, clear-on-compare auto reload, symmetric phase-correct PWM, and compare-driven square-wave generation. Each mode drives the waveform pin in its own way.

The overflow and compare events each set a sticky flag. Software clears a flag by writing a 1 to its bit, or with a one-cycle acknowledge pulse. Each flag reaches its interrupt output only when its mask bit is set. Direction is tracked by a two-state machine: RISE (counting up) and FALL (counting down). The machine goes from RISE to FALL on a tick at TOP (0xFF) in PWM mode. It goes from FALL to RISE on a tick at BOTTOM (0x00) in PWM mode. In any other mode it is forced back to RISE.

Register map (2-bit address): 0 = CTRL (bits 2:0 source select, bits 4:3 mode), 1 = COUNT, 2 = COMPARE, 3 = FLAGS (bit 0 overflow flag, bit 1 compare flag, bit 2 overflow mask, bit 3 compare mask). Mode codes: 0 wrap-around, 1 clear-on-compare, 2 phase-correct PWM, 3 square-wave.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset, all four registers read 0x00, and the waveform and both interrupt outputs are low.
- R2: With source select 0 the counter keeps its value on every cycle.
- R3: Source select codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 system clocks, taken from a free-running 10-bit divider.
- R4: Code 7 counts rising edges and code 6 counts falling edges of the external input. The opposite edge is ignored. The counter changes on the third clock edge after the input changes.
- R5: In mode 0 the counter wraps from 0xFF to 0x00. A tick at 0xFF sets the overflow flag (FLAGS bit 0).
- R6: In mode 1, a tick while the counter equals the compare value loads 0x00 and sets the compare flag (FLAGS bit 1).
- R7: In mode 2 the counter climbs to 0xFF, then steps down to 0x00, then climbs again. The tick at 0x00 while descending sets the overflow flag.
- R8: In mode 2, a COMPARE write takes effect only on the tick at 0xFF. COMPARE always reads back the last value written.
- R9: In mode 2, a compare match while rising drives the waveform low, and a match while falling drives it high. Modes 0 and 1 hold the waveform low.
- R10: In mode 3 the waveform toggles on each compare match and the counter clears, so the period is 2 x (compare + 1) ticks.
- R11: Writing a 1 to a flag bit clears that flag, and so does a pulse on its acknowledge input. A new event in the same cycle wins over the clear.
- R12: Each interrupt output is high exactly when its flag and its mask bit (FLAGS bits 2 and 3) are both set.
- R13: A COUNT write loads the written value and overrides a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_pin | input | 1 | External count input (asynchronous) |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| ack_cmp | input | 1 | Compare interrupt acknowledge |
| wave_out | output | 1 | Waveform output |
| irq_ovf | output | 1 | Masked overflow interrupt |
| irq_cmp | output | 1 | Masked compare interrupt |

## Verification
A wrong direction state shows up on the first tick after TOP or BOTTOM: COUNT then reads one step in the wrong direction, and the overflow flag fires at the wrong turning point. A compare register that skips the buffer shows up within one tick of a mid-period write, because the compare flag and the waveform edge then follow the new value too early. A divider or synchroniser fault shifts COUNT within one measurement window of 64 to 2048 clocks, or moves the external count by one clock edge.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 2'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 2'd3;
    localparam int NUM_TAPS = 5;

    typedef enum logic [1:0] {
        MODE_WRAP = 2'd0,
        MODE_CLR  = 2'd1,
        MODE_PWM  = 2'd2,
        MODE_SQW  = 2'd3
    } mode_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr8_tick.sv
module tmr8_tick #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic       ext_pin,
    output logic       tick
);
    import tmr8_pkg::*;

    // Divider exponent for each prescaled source code 1..5
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap;
    logic                sync1_q, sync2_q, sync3_q;
    logic                ext_rise, ext_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            sync3_q <= 1'b0;
        end else begin
            pre_q   <= pre_q + 1'b1;
            sync1_q <= ext_pin;
            sync2_q <= sync1_q;
            sync3_q <= sync2_q;
        end
    end

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        if (tap_shift(g) == 0) begin : g_full
            assign tap[g] = 1'b1;
        end else begin : g_div
            assign tap[g] = &pre_q[tap_shift(g)-1:0];
        end
    end

    assign ext_rise = sync2_q & ~sync3_q;
    assign ext_fall = ~sync2_q & sync3_q;

    always_comb begin
        unique case (src_sel)
            3'd0: tick = 1'b0;
            3'd1: tick = tap[0];
            3'd2: tick = tap[1];
            3'd3: tick = tap[2];
            3'd4: tick = tap[3];
            3'd5: tick = tap[4];
            3'd6: tick = ext_fall;
            3'd7: tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core #(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr8_pkg::mode_e  mode,
    input  logic             cnt_wr,
    input  logic [W-1:0]     cnt_wdata,
    input  logic [W-1:0]     cmp_buf,
    output logic [W-1:0]     cnt,
    output logic [W-1:0]     cmp_act,
    output tmr8_pkg::dir_e   dir,
    output logic             ovf_ev,
    output logic             cmp_ev
);
    import tmr8_pkg::*;

    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] BOTTOM = '0;

    dir_e         state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d, cmp_q, cmp_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIR_RISE;
            cnt_q   <= '0;
            cmp_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cmp_q   <= cmp_d;
        end
    end

    // Direction transitions
    always_comb begin
        state_d = state_q;
        if (mode != MODE_PWM) begin
            state_d = DIR_RISE;
        end else if (tick) begin
            unique case (state_q)
                DIR_RISE: if (cnt_q == TOP)    state_d = DIR_FALL;
                DIR_FALL: if (cnt_q == BOTTOM) state_d = DIR_RISE;
            endcase
        end
    end

    // Counter, compare shadow and event outputs
    always_comb begin
        cnt_d  = cnt_q;
        cmp_d  = (mode == MODE_PWM) ? cmp_q : cmp_buf;
        ovf_ev = 1'b0;
        cmp_ev = tick && (cnt_q == cmp_q);
        if (tick) begin
            unique case (mode)
                MODE_WRAP: begin
                    cnt_d  = cnt_q + 1'b1;
                    ovf_ev = (cnt_q == TOP);
                end
                MODE_CLR, MODE_SQW: begin
                    cnt_d  = (cnt_q == cmp_q) ? BOTTOM : cnt_q + 1'b1;
                    ovf_ev = (cnt_q == TOP);
                end
                MODE_PWM: begin
                    unique case (state_q)
                        DIR_RISE: begin
                            if (cnt_q == TOP) begin
                                cnt_d = cnt_q - 1'b1;
                                cmp_d = cmp_buf;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                        DIR_FALL: begin
                            if (cnt_q == BOTTOM) begin
                                cnt_d  = cnt_q + 1'b1;
                                ovf_ev = 1'b1;
                            end else begin
                                cnt_d = cnt_q - 1'b1;
                            end
                        end
                    endcase
                end
            endcase
        end
        if (cnt_wr) cnt_d = cnt_wdata;
    end

    assign cnt     = cnt_q;
    assign cmp_act = cmp_q;
    assign dir     = state_q;
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave (
    input  logic            clk,
    input  logic            rst_n,
    input  tmr8_pkg::mode_e mode,
    input  tmr8_pkg::dir_e  dir,
    input  logic            cmp_ev,
    output logic            wave
);
    import tmr8_pkg::*;

    logic wave_q, wave_d;

    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_d;
    end

    always_comb begin
        unique case (mode)
            MODE_WRAP, MODE_CLR: wave_d = 1'b0;
            MODE_SQW:            wave_d = cmp_ev ? ~wave_q : wave_q;
            MODE_PWM:            wave_d = cmp_ev ? (dir == DIR_FALL) : wave_q;
        endcase
    end

    assign wave = wave_q;
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm #(
    parameter int W     = 8,
    parameter int PRE_W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ext_pin,
    input  logic         ack_ovf,
    input  logic         ack_cmp,
    output logic         wave_out,
    output logic         irq_ovf,
    output logic         irq_cmp
);
    import tmr8_pkg::*;

    localparam int PAD_CTRL  = W - 5;
    localparam int PAD_FLAGS = W - 4;

    logic [2:0]   src_q;
    mode_e        mode_q;
    logic [W-1:0] cmp_buf_q;
    logic         f_ovf_q, f_cmp_q, m_ovf_q, m_cmp_q;
    logic         tick, cnt_wr, ovf_ev, cmp_ev, clr_ovf, clr_cmp;
    logic [W-1:0] cnt_q, cmp_act;
    dir_e         dir;

    assign cnt_wr  = bus_wr && (bus_addr == A_COUNT);
    assign clr_ovf = ack_ovf | (bus_wr && (bus_addr == A_FLAGS) && bus_wdata[0]);
    assign clr_cmp = ack_cmp | (bus_wr && (bus_addr == A_FLAGS) && bus_wdata[1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= '0;
            mode_q    <= MODE_WRAP;
            cmp_buf_q <= '0;
            f_ovf_q   <= 1'b0;
            f_cmp_q   <= 1'b0;
            m_ovf_q   <= 1'b0;
            m_cmp_q   <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CTRL) begin
                src_q  <= bus_wdata[2:0];
                mode_q <= mode_e'(bus_wdata[4:3]);
            end
            if (bus_wr && bus_addr == A_CMP) cmp_buf_q <= bus_wdata;
            if (bus_wr && bus_addr == A_FLAGS) begin
                m_ovf_q <= bus_wdata[2];
                m_cmp_q <= bus_wdata[3];
            end
            f_ovf_q <= (f_ovf_q & ~clr_ovf) | ovf_ev;
            f_cmp_q <= (f_cmp_q & ~clr_cmp) | cmp_ev;
        end
    end

    tmr8_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(src_q), .ext_pin(ext_pin), .tick(tick)
    );

    tmr8_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
        .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .cmp_buf(cmp_buf_q),
        .cnt(cnt_q), .cmp_act(cmp_act), .dir(dir),
        .ovf_ev(ovf_ev), .cmp_ev(cmp_ev)
    );

    tmr8_wave u_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .dir(dir),
        .cmp_ev(cmp_ev), .wave(wave_out)
    );

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{PAD_CTRL{1'b0}}, mode_q, src_q};
            A_COUNT: bus_rdata = cnt_q;
            A_CMP:   bus_rdata = cmp_buf_q;
            A_FLAGS: bus_rdata = {{PAD_FLAGS{1'b0}}, m_cmp_q, m_ovf_q, f_cmp_q, f_ovf_q};
        endcase
    end

    assign irq_ovf = f_ovf_q & m_ovf_q;
    assign irq_cmp = f_cmp_q & m_cmp_q;
endmodule

// File: rtl/tmr8_pwm_chk.sv
module tmr8_pwm_chk #(
    parameter int W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic [2:0]      src,
    input tmr8_pkg::mode_e mode,
    input logic [W-1:0]    cnt,
    input logic [W-1:0]    cmp_act,
    input logic            cnt_wr,
    input logic [W-1:0]    wdata,
    input logic            wave
);
    import tmr8_pkg::*;

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 3'd0 && !cnt_wr) |=> (cnt == $past(cnt))); // R2

    AST_CLR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLR && tick && cnt == cmp_act && !cnt_wr) |=> (cnt == '0)); // R6

    AST_PWM_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && tick && cnt == '1 && !cnt_wr) |=> (cnt == {{(W-1){1'b1}}, 1'b0})); // R7

    AST_CMP_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PWM && cnt != '1) |=> $stable(cmp_act)); // R8

    AST_SQW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SQW && tick && cnt == cmp_act) |=> (wave != $past(wave))); // R10

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata))); // R13
endmodule

bind tmr8_pwm tmr8_pwm_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .src(src_q), .mode(mode_q),
    .cnt(cnt_q), .cmp_act(cmp_act), .cnt_wr(cnt_wr), .wdata(bus_wdata),
    .wave(wave_out)
);

// File: tb/tmr8_pwm_test.sv
`timescale 1ns/1ps
module tmr8_pwm_test;
    localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CMP = 2'd2, A_FLG = 2'd3;
    localparam int M_WRAP = 0, M_CLR = 1, M_PWM = 2, M_SQW = 3;
    localparam int S_REG = 0, S_WAVE = 1, S_IOVF = 2, S_ICMP = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       ack_ovf = 1'b0;
    logic       ack_cmp = 1'b0;
    logic       wave_out, irq_ovf, irq_cmp;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    tmr8_pwm uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .wave_out(wave_out),
        .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin : mon
        item_t      it;
        logic [7:0] act;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.sel)
                S_REG:   act = bus_rdata;
                S_WAVE:  act = {7'b0, wave_out};
                S_IOVF:  act = {7'b0, irq_ovf};
                default: act = {7'b0, irq_cmp};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=0x%02h expected=0x%02h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] e);
        bus_addr = a;
        sb_q.push_back('{req: req, sel: S_REG, exp: e});
        step(1);
    endtask

    task automatic chk_pin(input string req, input int s, input logic e);
        sb_q.push_back('{req: req, sel: s, exp: {7'b0, e}});
        step(1);
    endtask

    // Exactly n ticks of source sel in mode m, then stop (mode kept)
    task automatic run(input int m, input int sel, input int n);
        wr(A_CTRL, 8'(m * 8 + sel));
        if (n > 1) step(n - 1);
        wr(A_CTRL, 8'(m * 8));
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk_reg("R1 ctrl", A_CTRL, 8'h00);
        chk_reg("R1 count", A_CNT, 8'h00);
        chk_reg("R1 cmp", A_CMP, 8'h00);
        chk_reg("R1 flags", A_FLG, 8'h00);
        chk_pin("R1 wave", S_WAVE, 1'b0);
        chk_pin("R1 irq_ovf", S_IOVF, 1'b0);

        // R2 stopped counter holds
        wr(A_CNT, 8'h05);
        step(20);
        chk_reg("R2 hold", A_CNT, 8'h05);

        // R13 write overrides a tick, then counting resumes
        wr(A_CTRL, 8'(M_WRAP * 8 + 1));
        wr(A_CNT, 8'h40);
        wr(A_CTRL, 8'(M_WRAP * 8));
        chk_reg("R13 load", A_CNT, 8'h41);

        // R5 wrap and overflow flag
        wr(A_FLG, 8'h03);
        wr(A_CNT, 8'hFE);
        run(M_WRAP, 1, 2);
        chk_reg("R5 wrap", A_CNT, 8'h00);
        chk_reg("R5 ovf flag", A_FLG, 8'h01);

        // R11 clear by write-one and by acknowledge
        wr(A_FLG, 8'h01);
        chk_reg("R11 w1c", A_FLG, 8'h00);
        wr(A_CNT, 8'hFF);
        run(M_WRAP, 1, 1);
        chk_reg("R11 set again", A_FLG, 8'h01);
        ack_ovf = 1'b1; step(1); ack_ovf = 1'b0;
        chk_reg("R11 ack", A_FLG, 8'h00);

        // R12 masking
        wr(A_FLG, 8'h07);
        wr(A_CNT, 8'hFF);
        run(M_WRAP, 1, 1);
        chk_pin("R12 irq_ovf on", S_IOVF, 1'b1);
        chk_pin("R12 irq_cmp off", S_ICMP, 1'b0);
        wr(A_FLG, 8'h05);
        chk_pin("R12 irq_ovf cleared", S_IOVF, 1'b0);
        chk_reg("R12 mask kept", A_FLG, 8'h04);

        // R6 clear-on-compare
        wr(A_CMP, 8'h05);
        wr(A_CNT, 8'h00);
        wr(A_FLG, 8'h0B);
        run(M_CLR, 1, 6);
        chk_reg("R6 reload", A_CNT, 8'h00);
        chk_reg("R6 cmp flag", A_FLG, 8'h0A);
        chk_pin("R12 irq_cmp on", S_ICMP, 1'b1);
        chk_pin("R9 wave low in mode 1", S_WAVE, 1'b0);
        run(M_CLR, 1, 2);
        chk_reg("R6 restart", A_CNT, 8'h02);
        wr(A_FLG, 8'h03);

        // R10 square wave, period 2*(3+1)
        wr(A_CMP, 8'h03);
        wr(A_CNT, 8'h00);
        run(M_SQW, 1, 4);
        chk_pin("R10 first toggle", S_WAVE, 1'b1);
        chk_reg("R10 cleared", A_CNT, 8'h00);
        run(M_SQW, 1, 4);
        chk_pin("R10 second toggle", S_WAVE, 1'b0);
        run(M_SQW, 1, 3);
        chk_pin("R10 no early toggle", S_WAVE, 1'b0);
        chk_reg("R10 count", A_CNT, 8'h03);
        run(M_SQW, 1, 1);
        chk_pin("R10 third toggle", S_WAVE, 1'b1);

        // R7 phase-correct turnarounds
        wr(A_FLG, 8'h03);
        wr(A_CNT, 8'hFD);
        run(M_PWM, 1, 3);
        chk_reg("R7 top turn", A_CNT, 8'hFE);
        wr(A_CNT, 8'h02);
        run(M_PWM, 1, 3);
        chk_reg("R7 bottom turn", A_CNT, 8'h01);
        chk_reg("R7 ovf at bottom", A_FLG, 8'h01);
        run(M_PWM, 1, 2);
        chk_reg("R7 rising again", A_CNT, 8'h03);

        // R8 buffered compare, R9 rising match clears output
        wr(A_FLG, 8'h03);
        wr(A_CMP, 8'h10);
        chk_reg("R8 readback", A_CMP, 8'h10);
        run(M_PWM, 1, 1);
        chk_reg("R8 old value still active", A_FLG, 8'h02);
        chk_pin("R9 rising match low", S_WAVE, 1'b0);
        wr(A_CNT, 8'hFE);
        run(M_PWM, 1, 2);
        wr(A_FLG, 8'h03);
        wr(A_CNT, 8'h11);
        run(M_PWM, 1, 2);
        chk_reg("R8 new value after top", A_FLG, 8'h02);
        chk_pin("R9 falling match high", S_WAVE, 1'b1);
        wr(A_CNT, 8'h01);
        run(M_PWM, 1, 17);
        chk_reg("R9 count before match", A_CNT, 8'h10);
        chk_pin("R9 held high", S_WAVE, 1'b1);
        run(M_PWM, 1, 1);
        chk_pin("R9 rising match low again", S_WAVE, 1'b0);
        chk_reg("R9 count after match", A_CNT, 8'h11);

        // R3 prescaler taps
        wr(A_CNT, 8'h00);
        run(M_WRAP, 2, 64);
        chk_reg("R3 div8", A_CNT, 8'd8);
        run(M_WRAP, 3, 128);
        chk_reg("R3 div64", A_CNT, 8'd10);
        run(M_WRAP, 4, 512);
        chk_reg("R3 div256", A_CNT, 8'd12);
        run(M_WRAP, 5, 2048);
        chk_reg("R3 div1024", A_CNT, 8'd14);

        // R4 external rising edges with synchroniser latency
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'(M_WRAP * 8 + 7));
        step(3);
        ext_pin = 1'b1;
        step(2);
        chk_reg("R4 not yet", A_CNT, 8'h00);
        chk_reg("R4 third edge", A_CNT, 8'h01);
        step(3);
        ext_pin = 1'b0;
        step(5);
        chk_reg("R4 falling ignored", A_CNT, 8'h01);
        ext_pin = 1'b1; step(4); ext_pin = 1'b0; step(4);
        chk_reg("R4 second rise", A_CNT, 8'h02);

        // R4 external falling edges
        wr(A_CTRL, 8'(M_WRAP * 8 + 6));
        wr(A_CNT, 8'h00);
        ext_pin = 1'b1;
        step(5);
        chk_reg("R4 rising ignored", A_CNT, 8'h00);
        ext_pin = 1'b0;
        step(4);
        chk_reg("R4 fall counted", A_CNT, 8'h01);

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule